// File: doc/BRIEF.md
# Dual-Width Address Arithmetic Unit

This block performs every address calculation of a processor core that supports two addressing widths. After reset it runs in a compatibility mode. In that mode each calculation wraps modulo 65536 on the low 16 bits, and the upper 16 bits of the operand pass through untouched. A one-way strobe moves it into an extended mode, where the same 32-bit datapath adds and subtracts across all 32 bits. Only reset brings it back to the compatibility mode.

The unit holds the program counter and the stack pointer. An instruction decoder presents a 4-bit operation code, a base operand and an offset operand each cycle. The unit returns the computed address combinationally and updates the PC or SP at the next clock edge. Offsets for indexed and relative forms are expected already sign-extended to 32 bits. The full 32-bit value always appears on the outputs; the two modes differ only in the width of the arithmetic.

Top module: `dual_addr_unit`

## Requirements
- R1: While `rstN` is low (asynchronous, active low), `wideMode` is 0 and `pcOut` and `spOut` are 0.
- R2: In compatibility mode (`wideMode`=0), opcodes 1 (base+1), 2 (base-1), 3 (base+offset), 4 (base-offset), 5 (indexed, base+offset), 6 (SP-relative, SP+offset) and 7 (PC-relative, PC+offset) give a `result` whose low 16 bits are the sum modulo 65536 and whose upper 16 bits equal the upper half of the first operand, with no carry or borrow out of bit 15.
- R3: In compatibility mode, opcode 8 (PC <= PC+offset) and opcode 9 (PC <= base) wrap the PC on 16 bits and leave `pcOut[31:16]` zero.
- R4: In compatibility mode, opcode 10 (push, SP <= SP-offset) and opcode 11 (pop, SP <= SP+offset) change only `spOut[15:0]`, modulo 65536, and keep `spOut[31:16]`.
- R5: In extended mode (`wideMode`=1), every operation of R2, R3 and R4 is computed on the full 32 bits, and the PC keeps its full 32-bit value.
- R6: A high `setWide` at a clock edge makes `wideMode` 1 from that edge on. An operation presented in the same cycle as the strobe still uses the old mode.
- R7: Once `wideMode` is 1, no opcode and no further `setWide` clears it; only reset does.
- R8: Opcode 12 (SP <= base) loads all 32 bits of `baseOp` into SP in either mode, and that upper half appears unchanged on `spOut` and in SP-relative results.
- R9: For opcode 10, `result` is the decremented SP; for opcode 11, `result` is the SP value before the increment.
- R10: Opcodes 0 and 13 to 15 change neither PC nor SP, and `result` equals `baseOp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 4 | Operation select (codes listed in R2 to R10) |
| baseOp | input | 32 | Base operand |
| offsOp | input | 32 | Offset operand, sign-extended by the caller |
| setWide | input | 1 | One-way strobe into extended mode |
| result | output | 32 | Computed address, combinational |
| pcOut | output | 32 | Program counter |
| spOut | output | 32 | Stack pointer |
| wideMode | output | 1 | 1 in extended mode |

## Verification
The properties assume that `opCode`, `baseOp` and `setWide` are settled well before each rising edge. They also assume that reset is held for at least one edge, so the mode register has a defined past when the sticky-mode and strobe properties first apply. The bench changes every input half a period away from the sampling edge. It asserts reset for several edges before the first operation and again before the final re-check. It presents offsets already sign-extended, because the unit's wrap rules are only claimed for operands in that form.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

  typedef enum logic [3:0] {
    OP_IDLE   = 4'd0,
    OP_INC    = 4'd1,
    OP_DEC    = 4'd2,
    OP_ADD    = 4'd3,
    OP_SUB    = 4'd4,
    OP_INDEX  = 4'd5,
    OP_SPREL  = 4'd6,
    OP_PCREL  = 4'd7,
    OP_PCSTEP = 4'd8,
    OP_PCLOAD = 4'd9,
    OP_PUSH   = 4'd10,
    OP_POP    = 4'd11,
    OP_SPLOAD = 4'd12
  } opSel_e;

  typedef enum logic [1:0] {
    A_BASE = 2'd0,
    A_SP   = 2'd1,
    A_PC   = 2'd2
  } aSel_e;

  typedef enum logic [1:0] {
    B_ZERO = 2'd0,
    B_ONE  = 2'd1,
    B_OFFS = 2'd2
  } bSel_e;

  // strobes from control to datapath
  typedef struct packed {
    aSel_e aSel;
    bSel_e bSel;
    logic  negB;
    logic  pcWr;
    logic  spWr;
    logic  resOld;
  } dwaCtrl_t;

endpackage

// File: rtl/dwa_ctrl.sv
module dwa_ctrl
  import dwa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] opCode,
  input  logic       setWide,
  output dwaCtrl_t   ctrl,
  output logic       wideMode
);

  // sticky mode flag: set by strobe, cleared by reset only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wideMode <= 1'b0;
    else if (setWide) wideMode <= 1'b1;
  end

  always_comb begin
    ctrl = '{aSel: A_BASE, bSel: B_ZERO, negB: 1'b0,
             pcWr: 1'b0, spWr: 1'b0, resOld: 1'b0};
    case (opCode)
      OP_INC:    ctrl.bSel = B_ONE;
      OP_DEC:    begin ctrl.bSel = B_ONE;  ctrl.negB = 1'b1; end
      OP_ADD,
      OP_INDEX:  ctrl.bSel = B_OFFS;
      OP_SUB:    begin ctrl.bSel = B_OFFS; ctrl.negB = 1'b1; end
      OP_SPREL:  begin ctrl.aSel = A_SP; ctrl.bSel = B_OFFS; end
      OP_PCREL:  begin ctrl.aSel = A_PC; ctrl.bSel = B_OFFS; end
      OP_PCSTEP: begin
        ctrl.aSel = A_PC; ctrl.bSel = B_OFFS; ctrl.pcWr = 1'b1;
      end
      OP_PCLOAD: ctrl.pcWr = 1'b1;
      OP_PUSH:   begin
        ctrl.aSel = A_SP; ctrl.bSel = B_OFFS;
        ctrl.negB = 1'b1; ctrl.spWr = 1'b1;
      end
      OP_POP:    begin
        ctrl.aSel = A_SP; ctrl.bSel = B_OFFS;
        ctrl.spWr = 1'b1; ctrl.resOld = 1'b1;
      end
      OP_SPLOAD: ctrl.spWr = 1'b1;
      default:   ;
    endcase
  end

endmodule

// File: rtl/dwa_datapath.sv
module dwa_datapath
  import dwa_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dwaCtrl_t          ctrl,
  input  logic              wideMode,
  input  logic [ADDR_W-1:0] baseOp,
  input  logic [ADDR_W-1:0] offsOp,
  output logic [ADDR_W-1:0] result,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut
);

  localparam int HI_W = ADDR_W - NARROW_W;
  localparam logic [ADDR_W-1:0] ONE_V = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] aVal, bRaw, bEff, wideSum, narrowSum, sum, pcNext;

  always_comb begin
    case (ctrl.aSel)
      A_SP:    aVal = spOut;
      A_PC:    aVal = pcOut;
      default: aVal = baseOp;
    endcase
    case (ctrl.bSel)
      B_ONE:   bRaw = ONE_V;
      B_OFFS:  bRaw = offsOp;
      default: bRaw = '0;
    endcase
    bEff = ctrl.negB ? (~bRaw + ONE_V) : bRaw;
  end

  // one adder for full width, one sliced adder whose carry stops at the split
  assign wideSum   = aVal + bEff;
  assign narrowSum = {aVal[ADDR_W-1:NARROW_W],
                      aVal[NARROW_W-1:0] + bEff[NARROW_W-1:0]};
  assign sum       = wideMode ? wideSum : narrowSum;

  assign result = ctrl.resOld ? aVal : sum;
  assign pcNext = wideMode ? sum : {{HI_W{1'b0}}, sum[NARROW_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcOut <= '0;
      spOut <= '0;
    end else begin
      if (ctrl.pcWr) pcOut <= pcNext;
      if (ctrl.spWr) spOut <= sum;
    end
  end

endmodule

// File: rtl/dual_addr_unit.sv
module dual_addr_unit
  import dwa_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        opCode,
  input  logic [ADDR_W-1:0] baseOp,
  input  logic [ADDR_W-1:0] offsOp,
  input  logic              setWide,
  output logic [ADDR_W-1:0] result,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut,
  output logic              wideMode
);

  dwaCtrl_t ctrl;

  dwa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opCode(opCode), .setWide(setWide),
    .ctrl(ctrl), .wideMode(wideMode)
  );

  dwa_datapath #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wideMode(wideMode),
    .baseOp(baseOp), .offsOp(offsOp),
    .result(result), .pcOut(pcOut), .spOut(spOut)
  );

endmodule

// File: rtl/dwa_checker.sv
module dwa_checker #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        opCode,
  input logic [ADDR_W-1:0] baseOp,
  input logic              setWide,
  input logic [ADDR_W-1:0] result,
  input logic [ADDR_W-1:0] pcOut,
  input logic [ADDR_W-1:0] spOut,
  input logic              wideMode
);

  localparam logic [ADDR_W-1:0] ONE_V = {{(ADDR_W-1){1'b0}}, 1'b1};

  assert_reset_mode_R1: assert property (@(posedge clk)
    !rstN |=> !wideMode);

  assert_inc_keeps_hi_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!wideMode && opCode == 4'd1) |->
      result[ADDR_W-1:NARROW_W] == baseOp[ADDR_W-1:NARROW_W]);

  assert_pc_hi_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wideMode |-> pcOut[ADDR_W-1:NARROW_W] == '0);

  assert_push_keeps_hi_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!wideMode && opCode == 4'd10) |=>
      spOut[ADDR_W-1:NARROW_W] == $past(spOut[ADDR_W-1:NARROW_W]));

  assert_wide_inc_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wideMode && opCode == 4'd1) |-> result == baseOp + ONE_V);

  assert_strobe_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    setWide |=> wideMode);

  assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    wideMode |=> wideMode);

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd0 || opCode >= 4'd13) |=> ($stable(pcOut) && $stable(spOut)));

endmodule

bind dual_addr_unit dwa_checker #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rstN(rstN), .opCode(opCode), .baseOp(baseOp),
  .setWide(setWide), .result(result), .pcOut(pcOut), .spOut(spOut),
  .wideMode(wideMode)
);

// File: tb/sim_dual_addr_unit.sv
`timescale 1ns/1ps
module sim_dual_addr_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [31:0] baseOp = '0, offsOp = '0;
  logic        setWide = 1'b0;
  logic [31:0] result, pcOut, spOut;
  logic        wideMode;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dual_addr_unit u0 (
    .clk(clk), .rstN(rstN), .opCode(opCode), .baseOp(baseOp),
    .offsOp(offsOp), .setWide(setWide), .result(result),
    .pcOut(pcOut), .spOut(spOut), .wideMode(wideMode)
  );

  // {op, base, offset, expected compat result, expected extended result}
  localparam logic [131:0] VEC_TAB [0:6] = '{
    {4'd1, 32'h1234FFFF, 32'h00000000, 32'h12340000, 32'h12350000},
    {4'd2, 32'hABCD0000, 32'h00000000, 32'hABCDFFFF, 32'hABCCFFFF},
    {4'd3, 32'h0001FFF0, 32'h00000020, 32'h00010010, 32'h00020010},
    {4'd4, 32'h00050004, 32'h00000010, 32'h0005FFF4, 32'h0004FFF4},
    {4'd5, 32'h7FFF8000, 32'hFFFFFFFF, 32'h7FFF7FFF, 32'h7FFF7FFF},
    {4'd5, 32'h00010000, 32'hFFFFFFFE, 32'h0001FFFE, 32'h0000FFFE},
    {4'd3, 32'h0000FFFF, 32'h00010001, 32'h00000000, 32'h00020000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // called just after a falling edge; leaves inputs applied and settled
  task automatic setIn(input logic [3:0] op, input logic [31:0] b,
                       input logic [31:0] o, input logic sw);
    opCode = op; baseOp = b; offsOp = o; setWide = sw;
    #2;
  endtask

  // crosses one rising edge, returns to idle inputs after the falling edge
  task automatic stepClk;
    @(negedge clk);
    opCode = 4'd0; setWide = 1'b0;
    #2;
  endtask

  task automatic walkTable(input bit wide, input string req);
    for (int i = 0; i < 7; i++) begin
      setIn(VEC_TAB[i][131:128], VEC_TAB[i][127:96], VEC_TAB[i][95:64], 1'b0);
      chk(req, result, wide ? VEC_TAB[i][31:0] : VEC_TAB[i][63:32]);
      stepClk();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk("R1", {31'd0, wideMode}, 32'd0);
    chk("R1", pcOut, 32'd0);
    chk("R1", spOut, 32'd0);
    rstN = 1'b1;
    stepClk();

    // R2 compat wrap on the vector table
    walkTable(1'b0, "R2");

    // R10 idle codes
    setIn(4'd0, 32'hCAFE1234, 32'h5, 1'b0);
    chk("R10", result, 32'hCAFE1234);
    stepClk();
    setIn(4'd14, 32'h0BAD0BAD, 32'h5, 1'b0);
    chk("R10", result, 32'h0BAD0BAD);
    stepClk();
    chk("R10", pcOut, 32'd0);
    chk("R10", spOut, 32'd0);

    // R8 full SP load in compat mode
    setIn(4'd12, 32'h5A5A0001, 32'h0, 1'b0);
    stepClk();
    chk("R8", spOut, 32'h5A5A0001);

    // R4 / R9 push and pop wrap low half
    setIn(4'd10, 32'h0, 32'h2, 1'b0);
    chk("R9", result, 32'h5A5AFFFF);
    stepClk();
    chk("R4", spOut, 32'h5A5AFFFF);
    setIn(4'd11, 32'h0, 32'h2, 1'b0);
    chk("R9", result, 32'h5A5AFFFF);
    stepClk();
    chk("R4", spOut, 32'h5A5A0001);

    // R8 upper half of SP reaches SP-relative result
    setIn(4'd6, 32'h0, 32'h10, 1'b0);
    chk("R8", result, 32'h5A5A0011);
    stepClk();

    // R3 PC load and step in compat mode
    setIn(4'd9, 32'h1234FFFE, 32'h0, 1'b0);
    stepClk();
    chk("R3", pcOut, 32'h0000FFFE);
    setIn(4'd8, 32'h0, 32'h3, 1'b0);
    stepClk();
    chk("R3", pcOut, 32'h00000001);

    // R2 PC-relative with negative offset
    setIn(4'd7, 32'h0, 32'hFFFFFFFE, 1'b0);
    chk("R2", result, 32'h0000FFFF);
    stepClk();

    // R6 strobe: same-cycle op uses old mode
    setIn(4'd1, 32'h0000FFFF, 32'h0, 1'b1);
    chk("R6", result, 32'h00000000);
    chk("R6", {31'd0, wideMode}, 32'd0);
    stepClk();
    chk("R6", {31'd0, wideMode}, 32'd1);
    setIn(4'd1, 32'h0000FFFF, 32'h0, 1'b0);
    chk("R6", result, 32'h00010000);
    stepClk();

    // R5 extended arithmetic
    walkTable(1'b1, "R5");
    setIn(4'd9, 32'h1234FFFE, 32'h0, 1'b0);
    stepClk();
    chk("R5", pcOut, 32'h1234FFFE);
    setIn(4'd8, 32'h0, 32'h3, 1'b0);
    stepClk();
    chk("R5", pcOut, 32'h12350001);
    setIn(4'd10, 32'h0, 32'h2, 1'b0);
    stepClk();
    chk("R5", spOut, 32'h5A59FFFF);

    // R7 repeated strobe and idle codes keep the mode
    setIn(4'd15, 32'h0, 32'h0, 1'b1);
    stepClk();
    chk("R7", {31'd0, wideMode}, 32'd1);
    chk("R10", pcOut, 32'h12350001);
    repeat (3) stepClk();
    chk("R7", {31'd0, wideMode}, 32'd1);

    // R7 / R1 only reset clears the mode
    rstN = 1'b0;
    #2;
    chk("R7", {31'd0, wideMode}, 32'd0);
    chk("R1", pcOut, 32'd0);
    repeat (2) stepClk();
    rstN = 1'b1;
    stepClk();
    setIn(4'd1, 32'h1234FFFF, 32'h0, 1'b0);
    chk("R1", result, 32'h12340000);
    stepClk();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule